// File: doc/BRIEF.md
# Line-Control Configured Serial Transmitter

This block is the transmit half of a legacy-style asynchronous serial port. A producer hands it one byte with a valid strobe while `ready_o` is high. The block then drives the frame onto `txd_o`: a low start bit, then 5 to 8 data bits least significant first, then an optional parity bit, then one or two high stop bits. The line idles high.

The frame format comes from an 8-bit line control byte, decoded with the usual legacy encoding. The bit period is set by a 16-bit divisor that counts pulses of an external reference tick, which runs at 115200 ticks per second of line time. The line control byte and the divisor are both captured when a byte is accepted, so the frame in flight keeps its format. A divisor of zero leaves the previously captured divisor in place. A break bit in the line control byte forces the line low without disturbing the frame timing underneath.

Top module: `sertx_top`

## Requirements
- R1: After reset `txd_o` is 1, `busy_o` is 0 and `ready_o` is 1.
- R2: A byte is accepted on a clock edge where `valid_i` and `ready_o` are both 1. `busy_o` is 1 and `ready_o` is 0 from the next cycle until the last stop bit ends. A byte offered while busy is not taken and does not change the frame on the line.
- R3: A frame starts with one 0 bit, followed by N data bits sent least significant bit first, where N = `line_ctl_i[1:0]` + 5.
- R4: The frame ends with one stop bit of value 1 when `line_ctl_i[2]` is 0, and with two when it is 1.
- R5: When `line_ctl_i[3]` is 1, a parity bit follows the data bits. It is computed over the N data bits only. With `line_ctl_i[4]` = 1 the parity is even (data plus parity has an even count of ones); with `line_ctl_i[4]` = 0 it is odd. When `line_ctl_i[3]` is 0 there is no parity bit.
- R6: Each bit lasts D pulses of `rate_tick_i`, where D is the active divisor. With the tick held high, each bit lasts D clock cycles and the whole frame lasts (1+N+P+S)·D cycles. Here P is the number of parity bits and S the number of stop bits.
- R7: A nonzero `divisor_i` present at acceptance becomes the active divisor. A zero divisor keeps the previous one, which is RESET_DIV (default 1) after reset.
- R8: Changing `line_ctl_i` (other than the break bit) or `divisor_i` after acceptance has no effect on the frame in progress.
- R9: While `line_ctl_i[6]` is 1, `txd_o` is 0 from the next cycle on. Clearing it restores the serialiser's level from the next cycle, and the frame's timing is unchanged.
- R10: While `rate_tick_i` is 0, the frame does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| rate_tick_i | input | 1 | Reference rate tick, one pulse per 115200th of a second of line time |
| line_ctl_i | input | 8 | Line control byte: [1:0] length-5, [2] two stop, [3] parity enable, [4] even parity, [6] break |
| divisor_i | input | 16 | Bit-period divisor in reference ticks; 0 keeps the previous value |
| data_i | input | 8 | Byte to transmit |
| valid_i | input | 1 | Byte offered |
| ready_o | output | 1 | Block can accept a byte |
| busy_o | output | 1 | Frame in progress |
| txd_o | output | 1 | Serial line output |

## Verification
Two pairs of events can fall in the same cycle. In the first, the break bit is raised in the middle of a data bit while the bit-period counter keeps stepping. The bench checks that the line goes low at once, comes back to the serialiser's level, and that the frame still ends on its computed cycle. In the second, a new byte is offered during a frame, and the line control byte and divisor are rewritten in the very cycle after acceptance. The bench checks every later bit against the originally captured format and checks that no second frame starts.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned LEN_W  = 4;
    localparam int unsigned MIN_LEN = 5;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PARITY,
        TX_STOP
    } tx_state_e;

    typedef struct packed {
        logic [LEN_W-1:0] nbits;
        logic             two_stop;
        logic             par_en;
        logic             par_even;
    } frame_cfg_t;

    function automatic logic [BYTE_W-1:0] len_mask(input logic [LEN_W-1:0] n);
        logic [BYTE_W-1:0] m;
        m = '0;
        for (int i = 0; i < BYTE_W; i++) begin
            if (i < int'(n)) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/sertx_lcr_decode.sv
module sertx_lcr_decode
    import sertx_pkg::*;
#(
    parameter int unsigned CTL_W = 8
) (
    input  logic [CTL_W-1:0] line_ctl_i,
    output frame_cfg_t       cfg_o,
    output logic             brk_o
);
    localparam int unsigned LenLsb  = 0;
    localparam int unsigned StopBit = 2;
    localparam int unsigned ParBit  = 3;
    localparam int unsigned EvenBit = 4;
    localparam int unsigned BrkBit  = 6;

    always_comb begin
        cfg_o.nbits    = LEN_W'(MIN_LEN) + LEN_W'(line_ctl_i[LenLsb +: 2]);
        cfg_o.two_stop = line_ctl_i[StopBit];
        cfg_o.par_en   = line_ctl_i[ParBit];
        cfg_o.par_even = line_ctl_i[EvenBit];
        brk_o          = line_ctl_i[BrkBit];
    end

    // R3
    nbits_range_chk: assert property (@(line_ctl_i) 1'b1 |-> (cfg_o.nbits >= 4'd5 && cfg_o.nbits <= 4'd8));

endmodule

// File: rtl/sertx_baud.sv
module sertx_baud #(
    parameter int unsigned DIV_W     = 16,
    parameter int unsigned RESET_DIV = 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             restart_i,
    input  logic [DIV_W-1:0] divisor_i,
    output logic             bit_en_o
);
    localparam logic [DIV_W-1:0] ResetDiv = DIV_W'(RESET_DIV);
    localparam logic [DIV_W-1:0] One      = DIV_W'(1);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [DIV_W-1:0] cnt;
    } baud_st_t;

    baud_st_t st_d, st_q;
    logic     at_last;

    always_comb begin
        st_d    = st_q;
        at_last = (st_q.cnt == st_q.div - One);
        bit_en_o = 1'b0;
        if (restart_i) begin
            if (divisor_i != '0) st_d.div = divisor_i;
            st_d.cnt = '0;
        end else if (tick_i) begin
            if (at_last) begin
                st_d.cnt = '0;
                bit_en_o = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + One;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.div <= ResetDiv;
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R7
    zero_div_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (restart_i && divisor_i == '0) |=> $stable(st_q.div));

    // R7
    div_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.div != '0);

    // R6
    cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt < st_q.div);

    // R10
    no_tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !restart_i) |=> $stable(st_q.cnt));

endmodule

// File: rtl/sertx_serializer.sv
module sertx_serializer
    import sertx_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              valid_i,
    input  logic [BYTE_W-1:0] data_i,
    input  frame_cfg_t        cfg_i,
    input  logic              bit_en_i,
    output logic              accept_o,
    output logic              ready_o,
    output logic              busy_o,
    output logic              line_o
);
    typedef struct packed {
        tx_state_e         state;
        frame_cfg_t        cfg;
        logic [BYTE_W-1:0] sh;
        logic [LEN_W-1:0]  left;
        logic              par;
        logic              line;
    } ser_st_t;

    ser_st_t st_d, st_q;

    assign ready_o  = (st_q.state == TX_IDLE);
    assign busy_o   = (st_q.state != TX_IDLE);
    assign accept_o = valid_i && ready_o;
    assign line_o   = st_q.line;

    always_comb begin
        st_d = st_q;
        unique case (st_q.state)
            TX_IDLE: begin
                st_d.line = 1'b1;
                if (accept_o) begin
                    st_d.cfg   = cfg_i;
                    st_d.sh    = data_i;
                    st_d.par   = (^(data_i & len_mask(cfg_i.nbits))) ^ ~cfg_i.par_even;
                    st_d.state = TX_START;
                    st_d.line  = 1'b0;
                end
            end
            TX_START: begin
                if (bit_en_i) begin
                    st_d.line  = st_q.sh[0];
                    st_d.sh    = st_q.sh >> 1;
                    st_d.left  = st_q.cfg.nbits - LEN_W'(1);
                    st_d.state = TX_DATA;
                end
            end
            TX_DATA: begin
                if (bit_en_i) begin
                    if (st_q.left == '0) begin
                        if (st_q.cfg.par_en) begin
                            st_d.state = TX_PARITY;
                            st_d.line  = st_q.par;
                        end else begin
                            st_d.state = TX_STOP;
                            st_d.line  = 1'b1;
                            st_d.left  = LEN_W'(st_q.cfg.two_stop);
                        end
                    end else begin
                        st_d.line = st_q.sh[0];
                        st_d.sh   = st_q.sh >> 1;
                        st_d.left = st_q.left - LEN_W'(1);
                    end
                end
            end
            TX_PARITY: begin
                if (bit_en_i) begin
                    st_d.state = TX_STOP;
                    st_d.line  = 1'b1;
                    st_d.left  = LEN_W'(st_q.cfg.two_stop);
                end
            end
            TX_STOP: begin
                if (bit_en_i) begin
                    if (st_q.left == '0) begin
                        st_d.state = TX_IDLE;
                    end else begin
                        st_d.left = st_q.left - LEN_W'(1);
                    end
                end
            end
            default: st_d.state = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.state <= TX_IDLE;
            st_q.cfg   <= '0;
            st_q.sh    <= '0;
            st_q.left  <= '0;
            st_q.par   <= 1'b0;
            st_q.line  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // R1
    idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.state == TX_IDLE) |-> st_q.line);

    // R3
    start_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> !st_q.line);

    // R4
    stop_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.state == TX_STOP) |-> st_q.line);

    // R8
    cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && $past(busy_o)) |-> $stable(st_q.cfg));

    // R2
    busy_refuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && valid_i && st_q.state != TX_STOP) |=> busy_o);

    // R10
    no_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!bit_en_i && busy_o) |=> $stable(st_q.state));

endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
#(
    parameter int unsigned DIV_W     = 16,
    parameter int unsigned RESET_DIV = 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             rate_tick_i,
    input  logic [7:0]       line_ctl_i,
    input  logic [DIV_W-1:0] divisor_i,
    input  logic [7:0]       data_i,
    input  logic             valid_i,
    output logic             ready_o,
    output logic             busy_o,
    output logic             txd_o
);
    frame_cfg_t cfg;
    logic       brk_req;
    logic       bit_en;
    logic       accept;
    logic       line;

    typedef struct packed {
        logic brk;
    } top_st_t;

    top_st_t st_d, st_q;

    sertx_lcr_decode #(.CTL_W(8)) dec_i (
        .line_ctl_i (line_ctl_i),
        .cfg_o      (cfg),
        .brk_o      (brk_req)
    );

    sertx_baud #(.DIV_W(DIV_W), .RESET_DIV(RESET_DIV)) baud_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (rate_tick_i),
        .restart_i (accept),
        .divisor_i (divisor_i),
        .bit_en_o  (bit_en)
    );

    sertx_serializer ser_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .valid_i  (valid_i),
        .data_i   (data_i),
        .cfg_i    (cfg),
        .bit_en_i (bit_en),
        .accept_o (accept),
        .ready_o  (ready_o),
        .busy_o   (busy_o),
        .line_o   (line)
    );

    always_comb begin
        st_d     = st_q;
        st_d.brk = brk_req;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.brk <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign txd_o = st_q.brk ? 1'b0 : line;

    // R9
    break_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        line_ctl_i[6] |=> !txd_o);

    // R9
    break_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!line_ctl_i[6] && !busy_o && !valid_i) |=> txd_o);

    // R2
    ready_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && ready_o) |=> (busy_o && !ready_o));

endmodule

// File: tb/sertx_top_tb_top.sv
module sertx_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick;
    logic [7:0]  lcr;
    logic [15:0] div;
    logic [7:0]  data;
    logic        valid;
    logic        ready, busy, txd;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int cur_div = 1;

    always #2 clk = ~clk;

    sertx_top dut_i (
        .clk_i(clk), .rst_ni(rst_n), .rate_tick_i(tick), .line_ctl_i(lcr),
        .divisor_i(div), .data_i(data), .valid_i(valid),
        .ready_o(ready), .busy_o(busy), .txd_o(txd)
    );

    // {line control, divisor, data}
    localparam int NVEC = 6;
    localparam logic [31:0] VEC [NVEC] = '{
        {8'h03, 16'd2, 8'hA5},
        {8'h00, 16'd3, 8'h1F},
        {8'h1B, 16'd1, 8'h37},
        {8'h0E, 16'd2, 8'h4C},
        {8'h19, 16'd0, 8'h0D},
        {8'h05, 16'd4, 8'h96}
    };

    task automatic check(input string req, input logic act, input logic exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
        end
    endtask

    // build expected frame bits from the requirements
    task automatic build(input logic [7:0] c, input logic [7:0] d,
                         output logic [11:0] bits, output int nb);
        int n;
        logic p;
        n = int'(c[1:0]) + 5;
        bits = '0;
        nb = 0;
        bits[nb] = 1'b0; nb++;
        p = 1'b0;
        for (int i = 0; i < n; i++) begin
            bits[nb] = d[i]; nb++;
            p ^= d[i];
        end
        if (c[3]) begin
            bits[nb] = c[4] ? p : ~p; nb++;
        end
        bits[nb] = 1'b1; nb++;
        if (c[2]) begin bits[nb] = 1'b1; nb++; end
    endtask

    // disturb: rewrite config and offer a byte right after acceptance (R2, R8)
    task automatic send(input logic [7:0] c, input logic [15:0] dv, input logic [7:0] d,
                        input bit disturb, input string req);
        logic [11:0] bits;
        int nb;
        build(c, d, bits, nb);
        if (dv != 0) cur_div = int'(dv);
        @(negedge clk);
        lcr = c; div = dv; data = d; valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        valid = 1'b0;
        if (disturb) begin
            lcr = c ^ 8'h1F; div = dv + 16'd5; data = ~d; valid = 1'b1;
        end
        for (int k = 0; k < nb; k++) begin
            check(req, txd, bits[k], $sformatf("bit %0d", k));
            check("R2", busy, 1'b1, "busy in frame");
            if (disturb && k == 2) valid = 1'b0;
            repeat (cur_div) @(negedge clk);
        end
        check("R6", busy, 1'b0, "busy after frame");
        check("R1", txd, 1'b1, "idle after frame");
        if (disturb) begin
            repeat (2 * cur_div + 2) @(negedge clk);
            check("R2", busy, 1'b0, "refused byte not sent");
            check("R2", txd, 1'b1, "line idle after refused byte");
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; tick = 1'b1; lcr = 8'h03; div = 16'd0; data = 8'h00; valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check("R1", txd, 1'b1, "reset txd");
        check("R1", busy, 1'b0, "reset busy");
        check("R1", ready, 1'b1, "reset ready");

        // R7: first frame with divisor 0 uses reset divisor 1
        send(8'h03, 16'd0, 8'h5A, 1'b0, "R7");

        // table: R3 R4 R5 R6 R7
        for (int v = 0; v < NVEC; v++) begin
            send(VEC[v][31:24], VEC[v][23:8], VEC[v][7:0], 1'b0, "R3/R4/R5");
        end

        // R8 and R2: rewrite config mid-frame, offer byte while busy
        send(8'h1F, 16'd3, 8'hC3, 1'b1, "R8");

        // R9: break while idle
        @(negedge clk);
        lcr = 8'h43;
        @(negedge clk);
        check("R9", txd, 1'b0, "break idle low");
        lcr = 8'h03;
        @(negedge clk);
        check("R9", txd, 1'b1, "break released");

        // R9: break mid-frame, timing unchanged (8N1, div 4, 10 bits = 40 cycles)
        @(negedge clk);
        lcr = 8'h03; div = 16'd4; data = 8'hFF; valid = 1'b1; cur_div = 4;
        @(posedge clk);
        @(negedge clk);
        valid = 1'b0;
        repeat (8) @(negedge clk);
        check("R9", txd, 1'b1, "data bit before break");
        lcr = 8'h43;
        @(negedge clk);
        check("R9", txd, 1'b0, "break forces low");
        check("R9", busy, 1'b1, "busy during break");
        lcr = 8'h03;
        @(negedge clk);
        check("R9", txd, 1'b1, "line restored");
        repeat (29) @(negedge clk);
        check("R9", busy, 1'b1, "frame still running");
        @(negedge clk);
        check("R9", busy, 1'b0, "frame ends on time");

        // R10: no tick, frame stalls
        @(negedge clk);
        tick = 1'b0; lcr = 8'h03; div = 16'd2; data = 8'hFF; valid = 1'b1; cur_div = 2;
        @(posedge clk);
        @(negedge clk);
        valid = 1'b0;
        repeat (20) @(negedge clk);
        check("R10", txd, 1'b0, "start bit held");
        check("R10", busy, 1'b1, "busy held");
        tick = 1'b1;
        repeat (19) @(negedge clk);
        check("R10", busy, 1'b1, "frame before end");
        @(negedge clk);
        check("R10", busy, 1'b0, "frame end after resume");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule